// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Write Sequencer

This block loads a configuration value into the internal tuning registers of a USB PHY one bit at a time through a single control word. The host places a first internal address, a bit count, a data word, a target port and a per-step hold time on the inputs, then pulses `start`. The data word is consumed from its least significant end. Each bit goes to the next internal address. It is committed by a short pulse on the strobe bit that belongs to the chosen port.

The control word is driven on `ctrlWord` for the PHY model to sample. Two layouts are supported, selected by `relocMode`. In the legacy layout the word comes out of reset as zero and sits at offset 0x04. In the relocated layout it sits at offset 0x10 and comes out of reset holding leftover contents. It must therefore be written to zero at the start of every transfer. `busy` covers the whole transfer and `done` marks its end.

Top module: `phy_cfg_seq`

## Requirements
- R1: During and after reset, `busy` and `done` are low. `ctrlWord` resets to zero when `relocMode` is 0 and to `RELOC_RESET_VAL` (default 0x5A5A5A4A) when it is 1. `ctrlOffset` reads 0x04 in the legacy layout and 0x10 in the relocated layout.
- R2: `start` is accepted only while `busy` is low. A `start` raised during a transfer, together with new operand values, changes neither that transfer's sequence nor its result.
- R3: Bit i of a transfer runs four steps in a fixed order. First, `ctrlWord[15:8]` is set to the start address plus i, modulo 256. Second, `ctrlWord[7]` takes the data bit and the port strobe is cleared. Third, the strobe is set. Fourth, the strobe is cleared.
- R4: Data bits are sent least significant first. Bit i of the transfer carries bit i of the data word.
- R5: The strobe for port p is `ctrlWord[2*p]`. A port index of `NUM_PORTS` or above pulses no strobe bit, and the other steps still run.
- R6: In the relocated layout, every transfer begins with a step that drives `ctrlWord` to all zeros before the first bit.
- R7: Each step, including the clearing step, holds its value for `holdCycles` clock cycles. A value of 0 is treated as 1.
- R8: `done` is high for exactly one cycle, in the cycle after the last step of the transfer ends. `busy` is low in that cycle and high for the whole transfer before it.
- R9: A bit count of 0 ends with `done` one cycle after start in the legacy layout, with `ctrlWord` unchanged. In the relocated layout it ends after only the clearing step.
- R10: Bits of `ctrlWord` outside the address field, the data bit and the active strobe keep their previous values through a transfer. The whole word holds its value while idle.
- R11: A `start` presented in the cycle where `done` is high is accepted, and the next transfer begins immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (single-cycle pulse, taken while idle) |
| relocMode | input | 1 | 1 selects the relocated layout; also picks the reset value |
| startAddr | input | 8 | First PHY-internal address |
| bitLen | input | LEN_W (6) | Number of bits to write |
| dataIn | input | DATA_W (32) | Data word, sent LSB first |
| portIdx | input | PORT_W (2) | Target PHY port |
| holdCycles | input | HOLD_W (4) | Cycles each step is held (0 means 1) |
| ctrlWord | output | WORD_W (32) | Control word seen by the PHY |
| ctrlOffset | output | 8 | Byte offset of the control word for the selected layout |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The end of one transfer and the acceptance of the next can fall in the same cycle. The `done` pulse marks the sequencer idle, and a `start` presented in that cycle must begin a new transfer without losing the pulse. The bench provokes this by raising `start` on the very cycle `done` is seen. It does so after a relocated transfer, after a zero-length transfer, and into an address that wraps. It then judges that `done` fell, that `busy` rose, and that the new step sequence began one cycle later with no idle gap.

// File: rtl/phy_cfg_seq_pkg.sv
package phy_cfg_seq_pkg;

  localparam int ADDR_LSB = 8;
  localparam int DATA_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZERO,
    ST_ADDR,
    ST_DATA,
    ST_SET,
    ST_CLR
  } seqState_t;

  typedef struct packed {
    logic loadOps;
    logic zeroWord;
    logic loadAddr;
    logic loadData;
    logic setStb;
    logic clrStb;
  } seqCmd_t;

endpackage

// File: rtl/phy_cfg_hold_timer.sv
module phy_cfg_hold_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic [HOLD_W-1:0] holdIn,
  input  logic              restart,
  output logic              last
);

  logic [HOLD_W-1:0] hQ;
  logic [HOLD_W-1:0] cntQ;
  logic [HOLD_W-1:0] hEff;

  assign hEff = (holdIn == '0) ? HOLD_W'(1) : holdIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hQ   <= HOLD_W'(1);
      cntQ <= HOLD_W'(1);
    end else if (arm) begin
      hQ   <= hEff;
      cntQ <= hEff;
    end else if (restart) begin
      cntQ <= hQ;
    end else if (cntQ > HOLD_W'(1)) begin
      cntQ <= cntQ - HOLD_W'(1);
    end
  end

  assign last = (cntQ == HOLD_W'(1));

endmodule

// File: rtl/phy_cfg_control.sv
module phy_cfg_control
  import phy_cfg_seq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             relocMode,
  input  logic [LEN_W-1:0] bitLen,
  input  logic             timerLast,
  output seqCmd_t          cmd,
  output logic             restart,
  output logic             busy,
  output logic             done
);

  seqState_t        stQ, stNext;
  logic [LEN_W-1:0] leftQ;
  logic             doneQ;
  logic             finish;

  always_comb begin
    cmd    = '0;
    stNext = stQ;
    finish = 1'b0;
    unique case (stQ)
      ST_IDLE: if (start) begin
        cmd.loadOps = 1'b1;
        if (relocMode) begin
          cmd.zeroWord = 1'b1;
          stNext       = ST_ZERO;
        end else if (bitLen == '0) begin
          finish = 1'b1;
        end else begin
          cmd.loadAddr = 1'b1;
          stNext       = ST_ADDR;
        end
      end
      ST_ZERO: if (timerLast) begin
        if (leftQ == '0) begin
          finish = 1'b1;
          stNext = ST_IDLE;
        end else begin
          cmd.loadAddr = 1'b1;
          stNext       = ST_ADDR;
        end
      end
      ST_ADDR: if (timerLast) begin
        cmd.loadData = 1'b1;
        stNext       = ST_DATA;
      end
      ST_DATA: if (timerLast) begin
        cmd.setStb = 1'b1;
        stNext     = ST_SET;
      end
      ST_SET: if (timerLast) begin
        cmd.clrStb = 1'b1;
        stNext     = ST_CLR;
      end
      ST_CLR: if (timerLast) begin
        if (leftQ == '0) begin
          finish = 1'b1;
          stNext = ST_IDLE;
        end else begin
          cmd.loadAddr = 1'b1;
          stNext       = ST_ADDR;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign restart = (stQ != ST_IDLE) && timerLast && !finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      leftQ <= '0;
      doneQ <= 1'b0;
    end else begin
      stQ   <= stNext;
      doneQ <= finish;
      if (cmd.loadOps)     leftQ <= bitLen;
      else if (cmd.clrStb) leftQ <= leftQ - LEN_W'(1);
    end
  end

  assign busy = (stQ != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/phy_cfg_datapath.sv
module phy_cfg_datapath
  import phy_cfg_seq_pkg::*;
#(
  parameter int              WORD_W    = 32,
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter int              NUM_PORTS = 3,
  parameter int              PORT_W    = 2,
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              relocMode,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [PORT_W-1:0] portIdx,
  output logic [WORD_W-1:0] ctrlWord
);

  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    dataQ;
  logic [WORD_W-1:0]    maskQ, maskNew;
  logic [WORD_W-1:0]    wordQ, wordNext;
  logic [NUM_PORTS-1:0] portHit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign portHit[p] = (portIdx == PORT_W'(p));
  end

  always_comb begin
    maskNew = '0;
    for (int p = 0; p < NUM_PORTS; p++) maskNew[2*p] = portHit[p];
  end

  always_comb begin
    wordNext = wordQ;
    if (cmd.zeroWord) wordNext = '0;
    if (cmd.loadAddr)
      wordNext[ADDR_LSB +: ADDR_W] = cmd.loadOps ? startAddr : addrQ;
    if (cmd.loadData) begin
      wordNext           = wordNext & ~maskQ;
      wordNext[DATA_BIT] = dataQ[0];
    end
    if (cmd.setStb) wordNext = wordNext | maskQ;
    if (cmd.clrStb) wordNext = wordNext & ~maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= relocMode ? RST_VAL : '0;
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else begin
      wordQ <= wordNext;
      if (cmd.loadOps) begin
        addrQ <= startAddr;
        dataQ <= dataIn;
        maskQ <= maskNew;
      end else if (cmd.clrStb) begin
        addrQ <= addrQ + ADDR_W'(1);
        dataQ <= dataQ >> 1;
      end
    end
  end

  assign ctrlWord = wordQ;

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
  import phy_cfg_seq_pkg::*;
#(
  parameter int                DATA_W          = 32,
  parameter int                LEN_W           = 6,
  parameter int                HOLD_W          = 4,
  parameter int                NUM_PORTS       = 3,
  parameter int                PORT_W          = 2,
  parameter int                WORD_W          = 32,
  parameter logic [WORD_W-1:0] RELOC_RESET_VAL = 32'h5A5A_5A4A,
  parameter logic [7:0]        LEGACY_OFFSET   = 8'h04,
  parameter logic [7:0]        RELOC_OFFSET    = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              relocMode,
  input  logic [7:0]        startAddr,
  input  logic [LEN_W-1:0]  bitLen,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [PORT_W-1:0] portIdx,
  input  logic [HOLD_W-1:0] holdCycles,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [7:0]        ctrlOffset,
  output logic              busy,
  output logic              done
);

  localparam int ADDR_W = 8;

  seqCmd_t cmd;
  logic    timerLast;
  logic    restart;

  phy_cfg_control #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .relocMode(relocMode),
    .bitLen(bitLen), .timerLast(timerLast), .cmd(cmd),
    .restart(restart), .busy(busy), .done(done)
  );

  phy_cfg_hold_timer #(.HOLD_W(HOLD_W)) timer_i (
    .clk(clk), .rstN(rstN), .arm(cmd.loadOps), .holdIn(holdCycles),
    .restart(restart), .last(timerLast)
  );

  phy_cfg_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .RST_VAL(RELOC_RESET_VAL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .relocMode(relocMode), .cmd(cmd),
    .startAddr(startAddr), .dataIn(dataIn), .portIdx(portIdx),
    .ctrlWord(ctrlWord)
  );

  assign ctrlOffset = relocMode ? RELOC_OFFSET : LEGACY_OFFSET;

endmodule

// File: rtl/phy_cfg_seq_checker.sv
module phy_cfg_seq_checker #(
  parameter int WORD_W    = 32,
  parameter int NUM_PORTS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              relocMode,
  input logic [WORD_W-1:0] ctrlWord,
  input logic              busy,
  input logic              done
);

  function automatic logic [WORD_W-1:0] strobeSpan();
    logic [WORD_W-1:0] m = '0;
    for (int p = 0; p < NUM_PORTS; p++) m[2*p] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] STB_ALL = strobeSpan();

  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r8_done_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r8_busy_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlWord & STB_ALL));

  a_r3_fields_stable_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $rose(|(ctrlWord & STB_ALL))) |-> $stable(ctrlWord[15:7]));

  a_r6_cleared_first: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && $past(relocMode)) |-> (ctrlWord == '0));

endmodule

bind phy_cfg_seq phy_cfg_seq_checker #(.WORD_W(WORD_W), .NUM_PORTS(NUM_PORTS)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .relocMode(relocMode),
  .ctrlWord(ctrlWord), .busy(busy), .done(done)
);

// File: tb/phy_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module phy_cfg_seq_tb_top;
  localparam int DATA_W = 32, LEN_W = 6, HOLD_W = 4, NUM_PORTS = 3, PORT_W = 2, WORD_W = 32;
  localparam logic [31:0] JUNK = 32'h5A5A_5A4A;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, relocMode = 1'b1;
  logic [7:0]        startAddr = '0;
  logic [LEN_W-1:0]  bitLen = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [PORT_W-1:0] portIdx = '0;
  logic [HOLD_W-1:0] holdCycles = HOLD_W'(1);
  logic [WORD_W-1:0] ctrlWord;
  logic [7:0]        ctrlOffset;
  logic              busy, done;

  int nChk = 0, nFail = 0, hCur = 1;
  bit pokeNow = 0, pokeClr = 0, finished = 0;
  logic [31:0] expWord;

  always #2.5 clk = ~clk;

  phy_cfg_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .relocMode(relocMode),
    .startAddr(startAddr), .bitLen(bitLen), .dataIn(dataIn), .portIdx(portIdx),
    .holdCycles(holdCycles), .ctrlWord(ctrlWord), .ctrlOffset(ctrlOffset),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic stepCheck(input logic [31:0] w, input string tag);
    for (int k = 0; k < hCur; k++) begin
      check(ctrlWord === w, tag, ctrlWord, w);
      check(busy === 1'b1 && done === 1'b0, {tag, " busy/done"}, {30'b0, busy, done}, 32'h2);
      if (pokeNow) begin
        start = 1'b1; startAddr = 8'hEE; dataIn = '1; bitLen = LEN_W'(1); portIdx = PORT_W'(1);
        pokeNow = 0; pokeClr = 1;
      end else if (pokeClr) begin
        start = 1'b0; pokeClr = 0;
      end
      @(negedge clk);
    end
  endtask

  // Starts at a falling edge; returns at the falling edge where done is expected.
  task automatic doXfer(input bit reloc, input logic [7:0] a, input int len,
                        input logic [31:0] d, input int port, input int hold, input string tag);
    logic [31:0] m;
    logic [31:0] ds;
    hCur = (hold == 0) ? 1 : hold;
    m = (port < NUM_PORTS) ? (32'd1 << (2 * port)) : 32'd0;
    relocMode = reloc; startAddr = a; bitLen = LEN_W'(len); dataIn = d;
    portIdx = PORT_W'(port); holdCycles = HOLD_W'(hold); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (reloc) begin
      expWord = '0;
      stepCheck(expWord, {tag, " clear step"});
    end
    ds = d;
    for (int i = 0; i < len; i++) begin
      expWord[15:8] = 8'(a + 8'(i));
      stepCheck(expWord, {tag, " addr step"});
      expWord = expWord & ~m;
      expWord[7] = ds[0];
      stepCheck(expWord, {tag, " data step"});
      expWord = expWord | m;
      stepCheck(expWord, {tag, " strobe set"});
      expWord = expWord & ~m;
      stepCheck(expWord, {tag, " strobe clear"});
      ds = ds >> 1;
    end
    check(done === 1'b1 && busy === 1'b0, {tag, " R8 done pulse"}, {30'b0, busy, done}, 32'h1);
    check(ctrlWord === expWord, {tag, " final word"}, ctrlWord, expWord);
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R8 done single cycle"}, {30'b0, busy, done}, 32'h0);
    check(ctrlWord === expWord, {tag, " R10 idle hold"}, ctrlWord, expWord);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset in relocated layout leaves leftover contents
    repeat (3) @(negedge clk);
    check(ctrlWord === JUNK, "R1 reset word relocated", ctrlWord, JUNK);
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {30'b0, busy, done}, 32'h0);
    check(ctrlOffset === 8'h10, "R1 relocated offset", {24'b0, ctrlOffset}, 32'h10);
    rstN = 1'b1;
    @(negedge clk);
    relocMode = 1'b0;
    #1;
    check(ctrlOffset === 8'h04, "R1 legacy offset", {24'b0, ctrlOffset}, 32'h04);
    @(negedge clk);
    expWord = JUNK;

    doXfer(0, 8'h20, 5, 32'b10110, 0, 1, "R3 R4 R10 legacy port0");
    idleCheck("legacy port0");
    doXfer(0, 8'h41, 4, 32'hA, 2, 3, "R5 R7 port2 hold3");
    idleCheck("port2");
    doXfer(0, 8'h7F, 3, 32'h5, 1, 0, "R7 hold zero");
    idleCheck("hold zero");
    doXfer(1, 8'h10, 3, 32'h6, 1, 2, "R6 relocated");
    doXfer(1, 8'h30, 2, 32'h1, 0, 1, "R6 R11 chained relocated");
    idleCheck("chained relocated");
    doXfer(0, 8'h55, 0, 32'hFFFF_FFFF, 0, 1, "R9 length zero legacy");
    doXfer(0, 8'hFE, 4, 32'hB, 0, 1, "R11 R3 chained wrap");
    idleCheck("wrap");
    doXfer(1, 8'h00, 0, 32'h0, 2, 2, "R9 length zero relocated");
    idleCheck("len0 relocated");
    doXfer(0, 8'h60, 3, 32'h7, 3, 1, "R5 port out of range");
    idleCheck("bad port");
    pokeNow = 1;
    doXfer(0, 8'h08, 3, 32'h3, 2, 2, "R2 start while busy");
    idleCheck("poke");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule